// File: doc/BRIEF.md
# Debug Security Permission Gate

This block sits between an external debug module and one processor hart and decides, cycle by cycle, whether the debugger may act on that hart. Two inputs grant permission. The machine-debug enable opens every privilege level. The sub-machine allow bit opens only the levels below machine mode. With neither input set, the block refuses entry to Debug Mode, program-buffer execution and the register, quick and memory abstract commands. Nothing is allowed by default.

Refused abstract commands leave an error code that stays set until the debugger clears it. Every other abstract command is then held off until that clear. The block also filters the debug triggers. Any write to a trigger's control register has its machine-mode match bit forced to zero if it asks for Debug Mode entry while machine debug is off. A trigger that asks for Debug Mode entry cannot fire in machine mode while machine debug is off, even if it was armed earlier. Last, the block drives a two-bit prioritised inhibit code to the trace encoder.

Top module: `dbg_sec_gate`

## Requirements
- R1: Debug is permitted when `mdbg_en` is 1, or when `hart_in_m` is 0 and `sub_allow` is 1. The enables are not registered, so a change applies to a request in the same cycle.
- R2: `halt_out` equals `halt_req` while debug is permitted and is 0 otherwise. A refused halt request stays pending, and `halt_out` rises in the first cycle that permission appears while `halt_req` is still held.
- R3: `pbuf_go` is 1 only when `pbuf_req` is 1 and debug is permitted.
- R4: An abstract command uses `cmd_type` 0 for register access, 1 for quick access and 2 for memory access. Any other type, presented while `cmderr` is 0, is refused and sets `cmderr` to 2 at the next clock edge.
- R5: A type 0, 1 or 2 command presented while debug is not permitted and `cmderr` is 0 is refused and sets `cmderr` to 6 at the next edge. This holds when `cmd_nohalt` is 1, and code 4 is never used in that case.
- R6: A permitted command of type 0 or 2, with `hart_halted` 0 and `cmd_nohalt` 0, is refused and sets `cmderr` to 4. Every other permitted command of type 0, 1 or 2 raises `cmd_go` in the same cycle and leaves `cmderr` unchanged.
- R7: While `cmderr` is nonzero, `cmd_go` stays 0 and commands do not change `cmderr`. Each `cmderr_w1c` bit set to 1 clears the matching `cmderr` bit at the next edge.
- R8: A write to trigger k (`trig_wr_sel[k]` = 1) stores `trig_m_q[k]` = `trig_wr_m` AND NOT (`trig_wr_dmode` AND NOT `mdbg_en`) and also records the action bit `trig_wr_dmode`. Both are 0 after reset.
- R9: `trig_fire[k]` follows `trig_match_raw[k]` when `hart_in_m` is 0. In machine mode it is 0 if `trig_m_q[k]` is 0. It is also 0 if the stored action is Debug Mode entry and `mdbg_en` is 0 at that moment.
- R10: `trace_inh` is 2'b01 when `hart_halted` is 1. Otherwise it is 2'b10 when debug is not permitted, and 2'b00 in every other case. It is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdbg_en | input | 1 | Machine-debug enable for this hart |
| sub_allow | input | 1 | Sub-machine debug allow |
| hart_in_m | input | 1 | Hart is executing in machine mode |
| hart_halted | input | 1 | Hart is halted in Debug Mode |
| halt_req | input | 1 | Halt request from the debug module |
| halt_out | output | 1 | Gated halt request to the hart |
| pbuf_req | input | 1 | Program-buffer execution request |
| pbuf_go | output | 1 | Program-buffer execution granted |
| cmd_valid | input | 1 | Abstract command presented |
| cmd_type | input | CMDTYPE_W | Abstract command type |
| cmd_nohalt | input | 1 | Command asks for access without halting |
| cmd_go | output | 1 | Abstract command granted this cycle |
| cmderr | output | 3 | Sticky abstract-command error code |
| cmderr_w1c | input | 3 | Write-1-to-clear mask for cmderr |
| trig_wr_sel | input | NTRIG | One-hot trigger control write strobe |
| trig_wr_m | input | 1 | Written machine-mode match bit |
| trig_wr_dmode | input | 1 | Written action: enter Debug Mode |
| trig_m_q | output | NTRIG | Stored machine-mode match bits |
| trig_match_raw | input | NTRIG | Comparator match per trigger |
| trig_fire | output | NTRIG | Filtered trigger fire per trigger |
| trace_inh | output | 2 | Trace-inhibit code |

## Verification
Most of the wrong state in this block is in `cmderr` and the per-trigger stored bits. A stuck or wrongly updated `cmderr` shows one edge after the command that caused it. It shows again on every later command, because a nonzero code silences `cmd_go`, so a bad sticky bit is seen at the next command. A bad stored match or action bit stays hidden until the hart is in machine mode with a raw match. The bench therefore mixes mode changes, enable flips and raw matches after every trigger write, and compares all outputs against the model every cycle.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  localparam int CMDERR_W = 3;
  typedef logic [CMDERR_W-1:0] cmderr_t;

  localparam cmderr_t ERR_NONE   = 3'd0;
  localparam cmderr_t ERR_NOTSUP = 3'd2;
  localparam cmderr_t ERR_HALT   = 3'd4;
  localparam cmderr_t ERR_SEC    = 3'd6;

  localparam logic [1:0] TRC_OPEN   = 2'b00;
  localparam logic [1:0] TRC_HALTED = 2'b01;
  localparam logic [1:0] TRC_SECURE = 2'b10;

  // machine mode needs the machine enable; lower modes accept either grant
  function automatic logic dbg_permit(input logic in_m, input logic en, input logic allow);
    return in_m ? en : (en | allow);
  endfunction

  // halted takes precedence over the security inhibit
  function automatic logic [1:0] trace_code(input logic halted, input logic permit);
    if (halted) return TRC_HALTED;
    if (!permit) return TRC_SECURE;
    return TRC_OPEN;
  endfunction

  function automatic logic trig_m_store(input logic wr_m, input logic wr_dmode, input logic en);
    return wr_m & ~(wr_dmode & ~en);
  endfunction
endpackage

// File: rtl/dsg_perm.sv
module dsg_perm
  import dsg_pkg::*;
(
  input  logic       mdbg_en,
  input  logic       sub_allow,
  input  logic       hart_in_m,
  input  logic       hart_halted,
  input  logic       halt_req,
  input  logic       pbuf_req,
  output logic       permit,
  output logic       halt_out,
  output logic       pbuf_go,
  output logic [1:0] trace_inh
);
  always_comb begin
    permit    = dbg_permit(hart_in_m, mdbg_en, sub_allow);
    halt_out  = halt_req & permit;
    pbuf_go   = pbuf_req & permit;
    trace_inh = trace_code(hart_halted, permit);
  end
endmodule

// File: rtl/dsg_abscmd.sv
module dsg_abscmd
  import dsg_pkg::*;
#(
  parameter int CMDTYPE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 permit,
  input  logic                 hart_halted,
  input  logic                 cmd_valid,
  input  logic [CMDTYPE_W-1:0] cmd_type,
  input  logic                 cmd_nohalt,
  input  cmderr_t              cmderr_w1c,
  output logic                 cmd_go,
  output cmderr_t              cmderr
);
  localparam logic [CMDTYPE_W-1:0] TYPE_REG   = CMDTYPE_W'(0);
  localparam logic [CMDTYPE_W-1:0] TYPE_QUICK = CMDTYPE_W'(1);
  localparam logic [CMDTYPE_W-1:0] TYPE_MEM   = CMDTYPE_W'(2);

  cmderr_t verdict;
  logic    supported;
  logic    accept;

  always_comb begin
    supported = (cmd_type == TYPE_REG) || (cmd_type == TYPE_QUICK) || (cmd_type == TYPE_MEM);
    if (!supported)
      verdict = ERR_NOTSUP;
    else if (!permit)
      verdict = ERR_SEC;
    else if ((cmd_type != TYPE_QUICK) && !hart_halted && !cmd_nohalt)
      verdict = ERR_HALT;
    else
      verdict = ERR_NONE;
    accept = cmd_valid && (cmderr == ERR_NONE);
    cmd_go = accept && (verdict == ERR_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmderr <= ERR_NONE;
    else if (accept && verdict != ERR_NONE)
      cmderr <= verdict;
    else
      cmderr <= cmderr & ~cmderr_w1c;
  end
endmodule

// File: rtl/dsg_trig_slot.sv
module dsg_trig_slot
  import dsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mdbg_en,
  input  logic hart_in_m,
  input  logic wr_sel,
  input  logic wr_m,
  input  logic wr_dmode,
  input  logic match_raw,
  output logic m_q,
  output logic fire
);
  logic dmode_q;
  logic m_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q     <= 1'b0;
      dmode_q <= 1'b0;
    end else if (wr_sel) begin
      m_q     <= trig_m_store(wr_m, wr_dmode, mdbg_en);
      dmode_q <= wr_dmode;
    end
  end

  // a trigger armed while enabled is still masked once the enable drops
  always_comb begin
    m_blocked = ~m_q | (dmode_q & ~mdbg_en);
    fire      = match_raw & ~(hart_in_m & m_blocked);
  end
endmodule

// File: rtl/dbg_sec_gate.sv
module dbg_sec_gate
  import dsg_pkg::*;
#(
  parameter int NTRIG     = 2,
  parameter int CMDTYPE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mdbg_en,
  input  logic                 sub_allow,
  input  logic                 hart_in_m,
  input  logic                 hart_halted,
  input  logic                 halt_req,
  output logic                 halt_out,
  input  logic                 pbuf_req,
  output logic                 pbuf_go,
  input  logic                 cmd_valid,
  input  logic [CMDTYPE_W-1:0] cmd_type,
  input  logic                 cmd_nohalt,
  output logic                 cmd_go,
  output logic [2:0]           cmderr,
  input  logic [2:0]           cmderr_w1c,
  input  logic [NTRIG-1:0]     trig_wr_sel,
  input  logic                 trig_wr_m,
  input  logic                 trig_wr_dmode,
  output logic [NTRIG-1:0]     trig_m_q,
  input  logic [NTRIG-1:0]     trig_match_raw,
  output logic [NTRIG-1:0]     trig_fire,
  output logic [1:0]           trace_inh
);
  logic permit;

  dsg_perm u_perm (
    .mdbg_en     (mdbg_en),
    .sub_allow   (sub_allow),
    .hart_in_m   (hart_in_m),
    .hart_halted (hart_halted),
    .halt_req    (halt_req),
    .pbuf_req    (pbuf_req),
    .permit      (permit),
    .halt_out    (halt_out),
    .pbuf_go     (pbuf_go),
    .trace_inh   (trace_inh)
  );

  dsg_abscmd #(.CMDTYPE_W(CMDTYPE_W)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .permit      (permit),
    .hart_halted (hart_halted),
    .cmd_valid   (cmd_valid),
    .cmd_type    (cmd_type),
    .cmd_nohalt  (cmd_nohalt),
    .cmderr_w1c  (cmderr_w1c),
    .cmd_go      (cmd_go),
    .cmderr      (cmderr)
  );

  for (genvar k = 0; k < NTRIG; k++) begin : g_trig
    dsg_trig_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .mdbg_en   (mdbg_en),
      .hart_in_m (hart_in_m),
      .wr_sel    (trig_wr_sel[k]),
      .wr_m      (trig_wr_m),
      .wr_dmode  (trig_wr_dmode),
      .match_raw (trig_match_raw[k]),
      .m_q       (trig_m_q[k]),
      .fire      (trig_fire[k])
    );
  end
endmodule

// File: rtl/dsg_checker.sv
module dsg_checker #(
  parameter int NTRIG     = 2,
  parameter int CMDTYPE_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mdbg_en,
  input logic                 sub_allow,
  input logic                 hart_in_m,
  input logic                 hart_halted,
  input logic                 halt_out,
  input logic                 pbuf_go,
  input logic                 cmd_valid,
  input logic [CMDTYPE_W-1:0] cmd_type,
  input logic                 cmd_go,
  input logic [2:0]           cmderr,
  input logic [2:0]           cmderr_w1c,
  input logic [NTRIG-1:0]     trig_wr_sel,
  input logic                 trig_wr_dmode,
  input logic [NTRIG-1:0]     trig_m_q,
  input logic [NTRIG-1:0]     trig_fire,
  input logic [1:0]           trace_inh
);
  logic locked_out;
  assign locked_out = hart_in_m ? !mdbg_en : !(mdbg_en | sub_allow);

  AST_HALT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked_out |-> !halt_out); // R2
  AST_PBUF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked_out |-> !pbuf_go); // R3
  AST_SEC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmderr == 3'd0 && cmd_type <= CMDTYPE_W'(2) && locked_out) |=> cmderr == 3'd6); // R5
  AST_NO_GO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmderr != 3'd0) |-> !cmd_go); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmderr != 3'd0 && cmderr_w1c == 3'd0) |=> $stable(cmderr)); // R7
  AST_TRIG_M_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr_sel[0] && trig_wr_dmode && !mdbg_en) |=> !trig_m_q[0]); // R8
  AST_FIRE_M_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (hart_in_m && !trig_m_q[0]) |-> !trig_fire[0]); // R9
  AST_TRACE_NO_11: assert property (@(posedge clk) disable iff (!rst_n)
    trace_inh != 2'b11); // R10
  AST_TRACE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    hart_halted |-> trace_inh == 2'b01); // R10
endmodule

bind dbg_sec_gate dsg_checker #(.NTRIG(NTRIG), .CMDTYPE_W(CMDTYPE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mdbg_en       (mdbg_en),
  .sub_allow     (sub_allow),
  .hart_in_m     (hart_in_m),
  .hart_halted   (hart_halted),
  .halt_out      (halt_out),
  .pbuf_go       (pbuf_go),
  .cmd_valid     (cmd_valid),
  .cmd_type      (cmd_type),
  .cmd_go        (cmd_go),
  .cmderr        (cmderr),
  .cmderr_w1c    (cmderr_w1c),
  .trig_wr_sel   (trig_wr_sel),
  .trig_wr_dmode (trig_wr_dmode),
  .trig_m_q      (trig_m_q),
  .trig_fire     (trig_fire),
  .trace_inh     (trace_inh)
);

// File: tb/test_dbg_sec_gate.sv
module test_dbg_sec_gate;
  localparam int NT = 2;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdbg_en = 0, sub_allow = 0, hart_in_m = 0, hart_halted = 0;
  logic halt_req = 0, pbuf_req = 0, cmd_valid = 0, cmd_nohalt = 0;
  logic [TW-1:0] cmd_type = '0;
  logic [2:0] cmderr_w1c = '0;
  logic [NT-1:0] trig_wr_sel = '0, trig_match_raw = '0;
  logic trig_wr_m = 0, trig_wr_dmode = 0;
  logic halt_out, pbuf_go, cmd_go;
  logic [2:0] cmderr;
  logic [NT-1:0] trig_m_q, trig_fire;
  logic [1:0] trace_inh;

  dbg_sec_gate #(.NTRIG(NT), .CMDTYPE_W(TW)) i_dbg_sec_gate (
    .clk(clk), .rst_n(rst_n), .mdbg_en(mdbg_en), .sub_allow(sub_allow),
    .hart_in_m(hart_in_m), .hart_halted(hart_halted), .halt_req(halt_req),
    .halt_out(halt_out), .pbuf_req(pbuf_req), .pbuf_go(pbuf_go),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_nohalt(cmd_nohalt),
    .cmd_go(cmd_go), .cmderr(cmderr), .cmderr_w1c(cmderr_w1c),
    .trig_wr_sel(trig_wr_sel), .trig_wr_m(trig_wr_m), .trig_wr_dmode(trig_wr_dmode),
    .trig_m_q(trig_m_q), .trig_match_raw(trig_match_raw), .trig_fire(trig_fire),
    .trace_inh(trace_inh)
  );

  always #10 clk = ~clk; // 50 MHz

  int vectors = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int ref_err = 0;
  bit ref_m[NT];
  bit ref_d[NT];

  task automatic cmp(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: inputs already applied after negedge; check, then advance model at posedge
  task automatic cycle(input string req);
    bit ok;
    int e_err;
    bit e_go, e_halt, e_pb;
    int e_trc;
    #5;
    if (mdbg_en) ok = 1;
    else if (!hart_in_m && sub_allow) ok = 1;
    else ok = 0;
    e_halt = halt_req && ok;
    e_pb = pbuf_req && ok;
    e_trc = hart_halted ? 1 : (ok ? 0 : 2);
    e_err = 0;
    if (cmd_type > 2) e_err = 2;
    else if (!ok) e_err = 6;
    else if (cmd_type != 1 && !hart_halted && !cmd_nohalt) e_err = 4;
    e_go = cmd_valid && ref_err == 0 && e_err == 0;
    cmp(req, "halt_out(R2)", halt_out, e_halt);
    cmp(req, "pbuf_go(R3)", pbuf_go, e_pb);
    cmp(req, "trace_inh(R10)", trace_inh, e_trc);
    cmp(req, "cmd_go(R6)", cmd_go, e_go);
    cmp(req, "cmderr(R7)", cmderr, ref_err);
    for (int k = 0; k < NT; k++) begin
      bit ef;
      ef = trig_match_raw[k];
      if (hart_in_m && (!ref_m[k] || (ref_d[k] && !mdbg_en))) ef = 0;
      cmp(req, $sformatf("trig_fire[%0d](R9)", k), trig_fire[k], ef);
      cmp(req, $sformatf("trig_m_q[%0d](R8)", k), trig_m_q[k], ref_m[k]);
    end
    @(posedge clk);
    if (cmd_valid && ref_err == 0 && e_err != 0) ref_err = e_err;
    else ref_err = ref_err & ~int'(cmderr_w1c);
    for (int k = 0; k < NT; k++)
      if (trig_wr_sel[k]) begin
        ref_m[k] = trig_wr_m && !(trig_wr_dmode && !mdbg_en);
        ref_d[k] = trig_wr_dmode;
      end
    @(negedge clk);
  endtask

  task automatic idle();
    cmd_valid = 0; cmderr_w1c = 0; trig_wr_sel = 0; halt_req = 0; pbuf_req = 0;
    trig_match_raw = 0; cmd_nohalt = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int k = 0; k < NT; k++) begin ref_m[k] = 0; ref_d[k] = 0; end
    repeat (3) @(negedge clk);
    // reset state: cmderr 0, stored trigger bits 0
    cmp("R7", "cmderr reset", cmderr, 0);
    cmp("R8", "trig_m_q reset", trig_m_q, 0);
    rst_n = 1;
    @(negedge clk);

    // R1/R2: locked out, halt pending, then enable in same cycle
    hart_in_m = 1; halt_req = 1; cycle("R2");
    cmp("R2", "halt denied", halt_out, 0);
    sub_allow = 1; cycle("R1"); // sub allow does not open machine mode
    hart_in_m = 0; cycle("R1"); // lower mode opens with allow
    cmp("R2", "halt granted while pending", halt_out, 1);
    sub_allow = 0; hart_in_m = 1; mdbg_en = 1; cycle("R1");
    mdbg_en = 0; idle();

    // R3 program buffer
    pbuf_req = 1; cycle("R3");
    cmp("R3", "pbuf denied", pbuf_go, 0);
    mdbg_en = 1; cycle("R3");
    cmp("R3", "pbuf granted", pbuf_go, 1);
    idle(); mdbg_en = 0;

    // R5: nohalt access while locked -> 6, not 4
    cmd_valid = 1; cmd_type = 0; cmd_nohalt = 1; cycle("R5");
    idle(); cycle("R5");
    cmp("R5", "cmderr security", cmderr, 6);
    // R7: sticky, blocks even a permitted command
    mdbg_en = 1; hart_halted = 1; cmd_valid = 1; cmd_type = 1; cycle("R7");
    cmp("R7", "no go while sticky", cmd_go, 0);
    idle(); cmderr_w1c = 3'b010; cycle("R7");
    idle(); cycle("R7");
    cmp("R7", "partial clear", cmderr, 4);
    cmderr_w1c = 3'b111; cycle("R7"); idle();
    // R6: permitted, halted -> go
    cmd_valid = 1; cmd_type = 2; cycle("R6");
    // R6: not halted, no nohalt -> 4
    hart_halted = 0; cmd_type = 0; cycle("R6");
    idle(); cmp("R6", "cmderr halt code", cmderr, 4);
    cmderr_w1c = 3'b111; cycle("R6"); idle();
    // R4 unsupported
    cmd_valid = 1; cmd_type = 8'd7; cycle("R4"); idle(); cycle("R4");
    cmp("R4", "cmderr notsup", cmderr, 2);
    cmderr_w1c = 3'b111; cycle("R4"); idle();

    // R8/R9 triggers
    mdbg_en = 1; trig_wr_sel = 2'b01; trig_wr_m = 1; trig_wr_dmode = 1; cycle("R8");
    idle(); trig_match_raw = 2'b11; hart_in_m = 1; cycle("R9");
    cmp("R9", "armed fires while enabled", trig_fire[0], 1);
    mdbg_en = 0; cycle("R9");
    cmp("R9", "armed masked after disable", trig_fire[0], 0);
    hart_in_m = 0; cycle("R9");
    idle(); trig_wr_sel = 2'b10; trig_wr_m = 1; trig_wr_dmode = 1; cycle("R8");
    idle(); cycle("R8");
    cmp("R8", "m bit cleared on write", trig_m_q[1], 0);
    trig_wr_sel = 2'b10; trig_wr_m = 1; trig_wr_dmode = 0; cycle("R8");
    idle(); hart_in_m = 1; trig_match_raw = 2'b10; cycle("R9");
    cmp("R9", "non-debug action fires", trig_fire[1], 1);
    idle();
    // R10 halted has priority
    hart_halted = 1; cycle("R10");
    cmp("R10", "halted code", trace_inh, 1);
    hart_halted = 0; cycle("R10");

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      mdbg_en = r[0]; sub_allow = r[1]; hart_in_m = r[2]; hart_halted = r[3] & r[4];
      halt_req = r[5]; pbuf_req = r[6]; cmd_valid = r[7];
      cmd_type = r[9:8] == 2'b11 ? 8'd5 : {6'd0, r[9:8]};
      cmd_nohalt = r[10];
      cmderr_w1c = (r[13:11] == 3'b111) ? 3'b111 : ((r[14] & r[15]) ? r[18:16] : 3'b000);
      trig_wr_sel = (r[19] & r[20]) ? r[22:21] : 2'b00;
      trig_wr_m = r[23]; trig_wr_dmode = r[24]; trig_match_raw = r[26:25];
      cycle("R1");
    end
    finish_up();
  end
endmodule